// File: doc/BRIEF.md
# ISA Plug-and-Play Card Configuration Controller

This block holds the card-level configuration state of a plug-and-play ISA expansion card. Host software reaches it through three I/O ports. A fixed address port selects an internal register index. A fixed write-data port writes to the selected register. A read-data port, whose location software chooses, returns the selected register. The block tracks the card through four states: wait-for-key, sleep, isolation and config. It keeps the card select number, the read-port location, the logical device number and a resource-data ready flag.

A single-cycle `key_start` input takes the place of initiation-key detection. The serial-identifier comparison is not part of this block. Resource bytes come from an external source over a ready/byte handshake, and this block pulses `res_next` to advance that source. Two more pulses go to neighbouring logic. `cfg_reload` tells the logical-device configuration to reload its defaults. `sid_reset` rewinds the serial-identifier pointer.

Top module: `pnp_cfg_fsm`

## Requirements
- R1: After a synchronous active-low reset the card is in wait-for-key (`card_state` 0). The select number, the read-port field and the logical device number are all 0. `cfg_reload` is high during reset and stays high through the first clock cycle after reset is released.
- R2: Encoding of `card_state`: wait-for-key=0, sleep=1, isolation=2, config=3. A `key_start` pulse moves the card from wait-for-key to sleep. In every other state `key_start` has no effect.
- R3: A write to I/O address 0x0279 loads the index in any state. The index then stays selected, so repeated data-port reads and writes reach the same register until 0x0279 is written again.
- R4: Writes to the write-data port at 0x0A79 have no effect in wait-for-key. In sleep, only index 0x03 (wake) has an effect.
- R5: A write of byte v to index 0x00 sets the read port to I/O address {6'b0, v, 2'b11}, but only while the card is in isolation. Reads are answered, with `io_rd_hit` high, only in isolation or config and only at that exact address.
- R6: A write of byte d to index 0x03 (wake) acts in sleep, isolation or config. If d equals the select number, the card goes to isolation when d is 0 and to config otherwise, and `sid_reset` is high for one cycle. If d does not match, the card goes to sleep.
- R7: Index 0x02 holds self-clearing command bits, and each command executes on the clock edge after its write. Bit 2 clears the select number and the read-port field. Bit 1 returns the card to wait-for-key and keeps the select number. Bit 0 raises `cfg_reload` for one cycle and keeps the select number.
- R8: Reading index 0x05 returns `res_ready` in bit 0 and zeros above it. Reading index 0x04 returns `res_byte`. A read of index 0x04 raises `res_next` in that same cycle only when `res_ready` is high.
- R9: Index 0x06 is the read/write select number and index 0x07 is the read/write logical device number. Writes to either take effect in isolation or config.
- R10: Reading any index other than 0x04 to 0x07 returns 0. `io_rdata` is 0 whenever `io_rd_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 16 | I/O address of the current cycle |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | Read data, combinational |
| io_rd_hit | output | 1 | High when the current read is claimed by this card |
| key_start | input | 1 | Stand-in for the initiation key |
| res_ready | input | 1 | Resource byte available |
| res_byte | input | 8 | Current resource byte |
| res_next | output | 1 | Advance the resource source |
| card_state | output | 2 | Current card state |
| cfg_reload | output | 1 | Reload logical-device defaults |
| sid_reset | output | 1 | Rewind the serial-identifier pointer |

## Verification
The read-port location is swept over all 256 values of its field while the card is in isolation. Each value is checked to hit at its computed address and to miss when the low address bits differ, which separates a correct bit placement from an off-by-one shift. All 256 index values are swept on reads in config, which separates the implemented registers from those that must read zero. Wake data is swept from 0 to 15 against a nonzero select number, which separates a match from a mismatch and a zero from a nonzero match. Writes made in wait-for-key, in sleep and in config are then shown through later reads and wake outcomes to have left the state untouched.

// File: rtl/pnp_cfg_pkg.sv
// Package: shared state encoding and register index constants for the
// plug-and-play card configuration controller.
package pnp_cfg_pkg;

    typedef enum logic [1:0] {
        ST_WFK   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_ISO   = 2'd2,
        ST_CFG   = 2'd3
    } card_st_e;

    localparam logic [7:0] IDX_RDPORT = 8'h00;
    localparam logic [7:0] IDX_CTRL   = 8'h02;
    localparam logic [7:0] IDX_WAKE   = 8'h03;
    localparam logic [7:0] IDX_RES    = 8'h04;
    localparam logic [7:0] IDX_STAT   = 8'h05;
    localparam logic [7:0] IDX_CSN    = 8'h06;
    localparam logic [7:0] IDX_LDN    = 8'h07;

    localparam int CMD_W        = 3;
    localparam int CMD_RELOAD   = 0;
    localparam int CMD_TO_WFK   = 1;
    localparam int CMD_CLR_CSN  = 2;

endpackage

// File: rtl/pnp_bus_decode.sv
// Module: pnp_bus_decode
// Decodes the bus strobes into an index write, a data write and a read
// select. Assumes the address and write ports are fixed parameters and
// that the read port lies in the first 1 KiB of I/O space, with the
// lowest two address bits both set.
module pnp_bus_decode #(
    parameter int          ADDR_W     = 16,
    parameter int          PORT_W     = 8,
    parameter logic [15:0] ADDR_PORT  = 16'h0279,
    parameter logic [15:0] WDATA_PORT = 16'h0A79
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [PORT_W-1:0] rdport,
    input  logic              rd_enable,
    output logic              idx_wr,
    output logic              data_wr,
    output logic              rd_sel
);
    localparam int HI_W = ADDR_W - PORT_W - 2;

    logic [ADDR_W-1:0] rd_addr;

    // Build the full read-port address from the programmed field.
    assign rd_addr = {{HI_W{1'b0}}, rdport, 2'b11};

    // Classify the current bus cycle.
    always_comb begin
        idx_wr  = io_wr && (io_addr == ADDR_PORT[ADDR_W-1:0]);
        data_wr = io_wr && (io_addr == WDATA_PORT[ADDR_W-1:0]);
        rd_sel  = io_rd && rd_enable && (io_addr == rd_addr);
    end

endmodule

// File: rtl/pnp_state_ctrl.sv
// Module: pnp_state_ctrl
// Card state machine covering wait-for-key, sleep, isolation and config.
// Assumes that a command return to wait-for-key wins over a wake write
// in the same cycle, and that wake writes are ignored in wait-for-key.
module pnp_state_ctrl
    import pnp_cfg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_start,
    input  logic              wake_wr,
    input  logic [DATA_W-1:0] wake_data,
    input  logic [DATA_W-1:0] csn,
    input  logic              cmd_wfk,
    output card_st_e          state,
    output logic              sid_reset
);
    card_st_e state_q, state_d;
    logic     wake_ok;
    logic     wake_match;

    // Wake writes count only outside wait-for-key.
    assign wake_ok    = wake_wr && (state_q != ST_WFK);
    assign wake_match = (wake_data == csn);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        if (cmd_wfk) begin
            state_d = ST_WFK;
        end else if (state_q == ST_WFK) begin
            if (key_start) state_d = ST_SLEEP;
        end else if (wake_ok) begin
            if (!wake_match)            state_d = ST_SLEEP;
            else if (wake_data == '0)   state_d = ST_ISO;
            else                        state_d = ST_CFG;
        end
    end

    // State register and serial-identifier rewind pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_WFK;
            sid_reset <= 1'b0;
        end else begin
            state_q   <= state_d;
            sid_reset <= wake_ok && wake_match && !cmd_wfk;
        end
    end

    assign state = state_q;

    assert_wfk_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WFK && !key_start) |=> (state_q == ST_WFK));

    assert_wfk_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WFK) |=> (state_q == ST_WFK || state_q == ST_SLEEP));

    assert_sid_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sid_reset |-> (state_q == ST_ISO || state_q == ST_CFG));

    assert_cmd_wfk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wfk |=> (state_q == ST_WFK));

endmodule

// File: rtl/pnp_card_regs.sv
// Module: pnp_card_regs
// Index, select number, read-port field, logical device number and the
// self-clearing command register, plus the read multiplexer. Assumes that
// data-port writes are already qualified as bus cycles; this module gates
// them by card state.
module pnp_card_regs
    import pnp_cfg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  card_st_e          state,
    input  logic              idx_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_sel,
    input  logic              res_ready,
    input  logic [DATA_W-1:0] res_byte,
    output logic [DATA_W-1:0] index,
    output logic [DATA_W-1:0] csn,
    output logic [PORT_W-1:0] rdport,
    output logic              cmd_wfk,
    output logic              cfg_reload,
    output logic [DATA_W-1:0] rdata,
    output logic              res_next
);
    logic [DATA_W-1:0] index_q, csn_q, ldn_q;
    logic [PORT_W-1:0] rdport_q;
    logic [CMD_W-1:0]  cmd_q;
    logic              reload_q;
    logic              wr_ok;
    logic              ctrl_wr;
    logic [DATA_W-1:0] rd_mux;

    // Data-port writes act only in isolation or config.
    assign wr_ok   = data_wr && (state == ST_ISO || state == ST_CFG);
    assign ctrl_wr = wr_ok && (index_q == IDX_CTRL);

    // Index register, loaded from the address port in any state.
    always_ff @(posedge clk) begin
        if (!rst_n)      index_q <= '0;
        else if (idx_wr) index_q <= wdata;
    end

    // Read-port field: written only in isolation, cleared by command.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rdport_q <= '0;
        else if (cmd_q[CMD_CLR_CSN])     rdport_q <= '0;
        else if (wr_ok && state == ST_ISO && index_q == IDX_RDPORT)
                                         rdport_q <= wdata[PORT_W-1:0];
    end

    // Select number register.
    always_ff @(posedge clk) begin
        if (!rst_n)                      csn_q <= '0;
        else if (cmd_q[CMD_CLR_CSN])     csn_q <= '0;
        else if (wr_ok && index_q == IDX_CSN) csn_q <= wdata;
    end

    // Logical device number register.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ldn_q <= '0;
        else if (wr_ok && index_q == IDX_LDN) ldn_q <= wdata;
    end

    // Command bits: latched on write, executed and cleared on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_q <= '0;
        else if (ctrl_wr) cmd_q <= wdata[CMD_W-1:0];
        else              cmd_q <= '0;
    end

    // Defaults-reload strobe, raised by reset and by command bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) reload_q <= 1'b1;
        else        reload_q <= cmd_q[CMD_RELOAD];
    end

    // Read multiplexer over the implemented indices.
    always_comb begin
        case (index_q)
            IDX_RES:  rd_mux = res_byte;
            IDX_STAT: rd_mux = {{(DATA_W-1){1'b0}}, res_ready};
            IDX_CSN:  rd_mux = csn_q;
            IDX_LDN:  rd_mux = ldn_q;
            default:  rd_mux = '0;
        endcase
    end

    assign rdata      = rd_sel ? rd_mux : '0;
    assign res_next   = rd_sel && (index_q == IDX_RES) && res_ready;
    assign index      = index_q;
    assign csn        = csn_q;
    assign rdport     = rdport_q;
    assign cmd_wfk    = cmd_q[CMD_TO_WFK];
    assign cfg_reload = reload_q;

    assert_rdport_iso_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdport_q != $past(rdport_q) && rdport_q != '0) |-> ($past(state) == ST_ISO));

    assert_cmd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != '0 && !ctrl_wr) |=> (cmd_q == '0));

    assert_csn_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_q[CMD_TO_WFK] || cmd_q[CMD_RELOAD]) && !cmd_q[CMD_CLR_CSN] && !wr_ok)
        |=> (csn_q == $past(csn_q)));

    assert_res_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_next |-> res_ready);

    assert_wfk_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WFK && !cmd_q[CMD_CLR_CSN]) |=> (csn_q == $past(csn_q) && ldn_q == $past(ldn_q)));

endmodule

// File: rtl/pnp_cfg_fsm.sv
// Module: pnp_cfg_fsm (top)
// Card-level plug-and-play configuration controller. It joins the bus
// decoder, the card state machine and the register file. Assumes one
// bus strobe per cycle, sampled at the rising clock edge for writes;
// read data is combinational from the address and the read strobe.
module pnp_cfg_fsm
    import pnp_cfg_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter logic [15:0] ADDR_PORT  = 16'h0279,
    parameter logic [15:0] WDATA_PORT = 16'h0A79
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rd_hit,
    input  logic              key_start,
    input  logic              res_ready,
    input  logic [DATA_W-1:0] res_byte,
    output logic              res_next,
    output logic [1:0]        card_state,
    output logic              cfg_reload,
    output logic              sid_reset
);
    localparam int PORT_W = DATA_W;

    card_st_e          state;
    logic              idx_wr, data_wr, rd_sel;
    logic              rd_enable;
    logic [DATA_W-1:0] index, csn;
    logic [PORT_W-1:0] rdport;
    logic              cmd_wfk;
    logic              wake_wr;

    // Reads are served only once the card has been woken.
    assign rd_enable = (state == ST_ISO) || (state == ST_CFG);
    assign wake_wr   = data_wr && (index == IDX_WAKE);

    pnp_bus_decode #(
        .ADDR_W     (ADDR_W),
        .PORT_W     (PORT_W),
        .ADDR_PORT  (ADDR_PORT),
        .WDATA_PORT (WDATA_PORT)
    ) u_dec (
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .rdport    (rdport),
        .rd_enable (rd_enable),
        .idx_wr    (idx_wr),
        .data_wr   (data_wr),
        .rd_sel    (rd_sel)
    );

    pnp_state_ctrl #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_start (key_start),
        .wake_wr   (wake_wr),
        .wake_data (io_wdata),
        .csn       (csn),
        .cmd_wfk   (cmd_wfk),
        .state     (state),
        .sid_reset (sid_reset)
    );

    pnp_card_regs #(
        .DATA_W (DATA_W),
        .PORT_W (PORT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .idx_wr     (idx_wr),
        .data_wr    (data_wr),
        .wdata      (io_wdata),
        .rd_sel     (rd_sel),
        .res_ready  (res_ready),
        .res_byte   (res_byte),
        .index      (index),
        .csn        (csn),
        .rdport     (rdport),
        .cmd_wfk    (cmd_wfk),
        .cfg_reload (cfg_reload),
        .rdata      (io_rdata),
        .res_next   (res_next)
    );

    assign io_rd_hit  = rd_sel;
    assign card_state = state;

    assert_no_read_asleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WFK || state == ST_SLEEP) |-> (!io_rd_hit && io_rdata == '0));

    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd_hit |-> (io_rdata == '0 && !res_next));

endmodule

// File: tb/sim_pnp_cfg_fsm.sv
`timescale 1ns/1ps
module sim_pnp_cfg_fsm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_rd_hit;
    logic        key_start = 1'b0;
    logic        res_ready = 1'b0;
    logic [7:0]  res_byte = '0;
    logic        res_next;
    logic [1:0]  card_state;
    logic        cfg_reload;
    logic        sid_reset;

    int checks = 0;
    int failures = 0;

    localparam logic [15:0] AP = 16'h0279;
    localparam logic [15:0] WP = 16'h0A79;
    localparam int WFK = 0, SLP = 1, ISO = 2, CFG = 3;

    pnp_cfg_fsm u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_rd_hit(io_rd_hit),
        .key_start(key_start), .res_ready(res_ready), .res_byte(res_byte),
        .res_next(res_next), .card_state(card_state), .cfg_reload(cfg_reload),
        .sid_reset(sid_reset)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic port_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_wr(AP, idx);
        bus_wr(WP, d);
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic hit,
                          output logic [7:0] d, output logic nxt);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2;
        hit = io_rd_hit; d = io_rdata; nxt = res_next;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic pulse_key();
        @(negedge clk); key_start = 1'b1;
        @(negedge clk); key_start = 1'b0;
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] idx, input logic [7:0] c,
                                          input logic [7:0] l, input logic rdy,
                                          input logic [7:0] b);
        case (idx)
            8'h04:   return b;
            8'h05:   return {7'b0, rdy};
            8'h06:   return c;
            8'h07:   return l;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic       h, n;
        logic [7:0] d;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state and reload strobe
        chk("R1 state", card_state, WFK);
        chk("R1 reload in reset", cfg_reload, 1);
        rst_n = 1'b1;
        #1 chk("R1 reload first cycle", cfg_reload, 1);
        @(negedge clk);
        chk("R1 reload drops", cfg_reload, 0);

        // R4: data writes ignored in wait-for-key (wake 0 would match csn 0)
        port_wr(8'h03, 8'h00);
        chk("R4 wake ignored in wfk", card_state, WFK);
        bus_rd(16'h0003, h, d, n);
        chk("R5 no read in wfk", h, 0);

        // R2: key moves to sleep, ignored in sleep
        pulse_key();
        chk("R2 key to sleep", card_state, SLP);
        pulse_key();
        chk("R2 key ignored in sleep", card_state, SLP);

        // R4: in sleep only wake acts: read-port and csn writes ignored
        port_wr(8'h00, 8'h10);
        port_wr(8'h06, 8'h09);
        chk("R4 sleep writes keep state", card_state, SLP);
        bus_rd(16'h0003, h, d, n);
        chk("R5 no read in sleep", h, 0);

        // R6: wake 0 matching csn 0 -> isolation, sid pulse
        port_wr(8'h03, 8'h00);
        chk("R6 sid pulse", sid_reset, 1);
        chk("R6 wake0 to iso", card_state, ISO);
        chk("R4 csn untouched in sleep", card_state, ISO);
        bus_rd(16'h0003, h, d, n);
        chk("R4 rdport untouched in sleep", h, 1);
        @(negedge clk);
        chk("R6 sid one cycle", sid_reset, 0);

        // R5: sweep the read-port field in isolation; R3 index stays at 0
        bus_wr(AP, 8'h00);
        for (int v = 0; v < 256; v++) begin
            bus_wr(WP, v[7:0]);
            bus_rd({6'b0, v[7:0], 2'b11}, h, d, n);
            chk("R5 port hit", h, 1);
            chk("R10 index0 reads zero", d, 0);
            bus_rd({6'b0, v[7:0], 2'b01}, h, d, n);
            chk("R5 port miss low bits", h, 0);
        end
        bus_wr(WP, 8'h80);   // port 0x0203

        // R9: csn and ldn read/write in isolation
        port_wr(8'h06, 8'h05);
        bus_rd(16'h0203, h, d, n);
        chk("R9 csn readback", d, 8'h05);
        port_wr(8'h07, 8'h03);
        bus_rd(16'h0203, h, d, n);
        chk("R9 ldn readback", d, 8'h03);

        // R6: wake 5 -> config
        port_wr(8'h03, 8'h05);
        chk("R6 wake nonzero to cfg", card_state, CFG);

        // R5: read-port write ignored in config
        port_wr(8'h00, 8'h22);
        bus_rd(16'h0203, h, d, n);
        chk("R5 port fixed in cfg", h, 1);

        // R8 R10: sweep all indices in config
        res_ready = 1'b1; res_byte = 8'hA5;
        for (int i = 0; i < 256; i++) begin
            bus_wr(AP, i[7:0]);
            bus_rd(16'h0203, h, d, n);
            chk("R10 index sweep", d, exp_rd(i[7:0], 8'h05, 8'h03, 1'b1, 8'hA5));
            chk("R8 res_next by index", n, (i == 4) ? 1 : 0);
        end

        // R3 R8: index 4 stays selected across reads with a changing byte
        bus_wr(AP, 8'h04);
        for (int k = 0; k < 4; k++) begin
            res_byte = 8'h30 + k[7:0];
            bus_rd(16'h0203, h, d, n);
            chk("R3 repeated resource read", d, 8'h30 + k);
        end
        res_ready = 1'b0;
        bus_rd(16'h0203, h, d, n);
        chk("R8 no advance when not ready", n, 0);
        bus_wr(AP, 8'h05);
        bus_rd(16'h0203, h, d, n);
        chk("R8 status not ready", d, 0);
        res_ready = 1'b1;
        bus_rd(16'h0203, h, d, n);
        chk("R8 status ready", d, 1);

        // R6: wake sweep against csn 5
        for (int w = 0; w < 16; w++) begin
            port_wr(8'h03, w[7:0]);
            chk("R6 wake sweep", card_state, (w == 5) ? CFG : SLP);
            if (w != 5) port_wr(8'h03, 8'h05);
        end

        // R7: bit 0 pulses reload, keeps csn and state
        port_wr(8'h02, 8'h01);
        chk("R7 reload not yet", cfg_reload, 0);
        @(negedge clk);
        chk("R7 reload pulse", cfg_reload, 1);
        @(negedge clk);
        chk("R7 reload clears", cfg_reload, 0);
        bus_wr(AP, 8'h06);
        bus_rd(16'h0203, h, d, n);
        chk("R7 csn kept after reload", d, 8'h05);

        // R7: bit 1 returns to wait-for-key, csn kept
        port_wr(8'h02, 8'h02);
        @(negedge clk);
        chk("R7 to wfk", card_state, WFK);
        pulse_key();
        port_wr(8'h03, 8'h05);
        chk("R7 csn kept after wfk", card_state, CFG);

        // R7: bit 2 clears csn and read port
        port_wr(8'h02, 8'h04);
        @(negedge clk);
        chk("R7 state kept after clear", card_state, CFG);
        bus_wr(AP, 8'h06);
        bus_rd(16'h0203, h, d, n);
        chk("R7 old port gone", h, 0);
        bus_rd(16'h0003, h, d, n);
        chk("R7 port cleared", h, 1);
        chk("R7 csn cleared", d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule